// File: doc/BRIEF.md
# Floating-Point Register Stack Push Unit

This block holds an eight-entry stack of 80-bit extended-precision registers. It is addressed through a rotating 3-bit top pointer, and each physical register carries a one-bit valid tag. The block performs the load (push) step of the floating-point unit. An operand arrives as an opcode byte, a ModRM byte and, for memory forms, a value that has already been converted to 80-bit form. The block checks for stack faults, moves the top pointer down by one, writes the new top register and reports the outcome through a condition bit and a stack-fault flag.

Four load encodings are recognised: 32-bit, 64-bit and 80-bit memory sources, and a copy of a stack register. The stack-register source is addressed relative to the top pointer as it stood before the push, so a push of ST(0) duplicates the top entry. A read port gives any register relative to the current top, together with its tag. The pipeline that owns the stack uses this port, and the port also makes the stack observable.

Top module: `fpstk_push_unit`

## Requirements
- R1: After reset the top pointer is 0, every tag reads empty, and done, stack_fault and cond_c1 are 0.
- R2: The accepted forms and their form_out codes are: 0 = opcode 0xD9 with ModRM mod not 3 and reg field (bits 5:3) 0; 1 = opcode 0xDD with mod not 3 and reg 0; 2 = opcode 0xDB with mod not 3 and reg 5; 3 = opcode 0xD9 with ModRM 0xC0+i, where i is ModRM bits 2:0. form_out is valid while done is high.
- R3: Any other opcode/ModRM combination presented with op_valid is ignored. done stays 0, and the top pointer, the tags, the register contents and cond_c1 keep their values.
- R4: A memory-form push with no fault moves the top pointer to (top-1) mod 8 and writes mem_value into the new ST(0), tagged valid. Every older entry then reads back at a relative index one higher.
- R5: A stack-register push reads ST(i) relative to the top before the push. With i = 0 the new ST(0) equals the previous ST(0).
- R6: A push overflows when the physical register at (top-1) mod 8 is already tagged valid. An overflow sets cond_c1 = 1 and stack_fault = 1. Every accepted push without overflow clears cond_c1 to 0.
- R7: A stack-register push whose ST(i) is tagged empty, and which does not overflow, gives stack_fault = 1 and cond_c1 = 0.
- R8: On a fault with inv_mask = 1, the real-indefinite value 0xFFFF_C000_0000_0000_0000 (sign 1, exponent all ones, two top mantissa bits 1, the rest 0) is pushed in place of the source, and the top pointer moves as in R4.
- R9: On a fault with inv_mask = 0, the top pointer, the tags and the register contents are left unchanged.
- R10: Results appear one cycle after the op_valid cycle. done is high for exactly that cycle, and stack_fault is high only together with done. cond_c1 holds between pushes. Pushes on consecutive cycles are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 8 | Opcode byte |
| op_modrm | input | 8 | ModRM byte |
| mem_value | input | 80 | Memory operand, already converted to 80 bits |
| inv_mask | input | 1 | Invalid-operation mask (1 = masked) |
| rd_idx | input | 3 | Read index relative to current top |
| rd_value | output | 80 | Contents of ST(rd_idx) |
| rd_tag_valid | output | 1 | Tag of ST(rd_idx), 1 = valid |
| top_ptr | output | 3 | Current top-of-stack pointer |
| done | output | 1 | One-cycle completion strobe for an accepted push |
| form_out | output | 2 | Decoded source form of the completed push |
| cond_c1 | output | 1 | Condition bit C1 |
| stack_fault | output | 1 | Stack overflow/underflow indication |

## Verification
An underflow needs a register-source push that points past the valid entries while the slot below the top is still free. Only a partly filled stack gives that situation, and the stack can only be emptied by reset. The stimulus therefore resets the block, fills it to every depth from one to seven, and then pushes each ST(i) with the mask both set and clear. A full opcode sweep over 0xD8 to 0xDF with all 256 ModRM values then drives the stack repeatedly into overflow, with a variety of masks.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

   typedef enum logic [1:0] {
      SRC_M32 = 2'd0,
      SRC_M64 = 2'd1,
      SRC_M80 = 2'd2,
      SRC_STK = 2'd3
   } src_form_e;

   localparam logic [7:0] OPC_GRP_A = 8'hD9;
   localparam logic [7:0] OPC_GRP_B = 8'hDB;
   localparam logic [7:0] OPC_GRP_C = 8'hDD;
   localparam logic [2:0] REG_LD32  = 3'd0;
   localparam logic [2:0] REG_LD64  = 3'd0;
   localparam logic [2:0] REG_LD80  = 3'd5;
   localparam logic [4:0] STK_PREFIX = 5'b11000;

endpackage

// File: rtl/fpstk_decode.sv
module fpstk_decode
   import fpstk_pkg::*;
(
   input  logic       op_valid,
   input  logic [7:0] op_code,
   input  logic [7:0] op_modrm,
   output logic       accept,
   output src_form_e  form,
   output logic [2:0] idx
);

   logic       is_mem;
   logic [2:0] reg_f;

   assign is_mem = (op_modrm[7:6] != 2'b11);
   assign reg_f  = op_modrm[5:3];
   assign idx    = op_modrm[2:0];

   always_comb begin
      accept = 1'b0;
      form   = SRC_M32;
      if (op_valid) begin
         if (op_code == OPC_GRP_A && is_mem && reg_f == REG_LD32) begin
            accept = 1'b1;
            form   = SRC_M32;
         end else if (op_code == OPC_GRP_C && is_mem && reg_f == REG_LD64) begin
            accept = 1'b1;
            form   = SRC_M64;
         end else if (op_code == OPC_GRP_B && is_mem && reg_f == REG_LD80) begin
            accept = 1'b1;
            form   = SRC_M80;
         end else if (op_code == OPC_GRP_A && op_modrm[7:3] == STK_PREFIX) begin
            accept = 1'b1;
            form   = SRC_STK;
         end
      end
   end

endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 80,
   parameter int PTR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  src_addr,
   output logic [DATA_W-1:0] src_data,
   output logic              src_tag,
   input  logic [PTR_W-1:0]  obs_addr,
   output logic [DATA_W-1:0] obs_data,
   output logic              obs_tag,
   output logic              tgt_tag
);

   logic [DATA_W-1:0] ent_data [DEPTH];
   logic [DEPTH-1:0]  ent_tag;
   logic [DATA_W-1:0] src_terms [DEPTH];
   logic [DATA_W-1:0] obs_terms [DEPTH];
   logic [DEPTH-1:0]  src_sel, obs_sel, tgt_sel;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit_w;
      assign hit_w = wr_en && (wr_addr == PTR_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_data[e] <= '0;
            ent_tag[e]  <= 1'b0;
         end else if (hit_w) begin
            ent_data[e] <= wr_data;
            ent_tag[e]  <= 1'b1;
         end
      end

      assign src_sel[e]   = (src_addr == PTR_W'(e));
      assign obs_sel[e]   = (obs_addr == PTR_W'(e));
      assign tgt_sel[e]   = (wr_addr  == PTR_W'(e));
      assign src_terms[e] = src_sel[e] ? ent_data[e] : '0;
      assign obs_terms[e] = obs_sel[e] ? ent_data[e] : '0;
   end

   always_comb begin
      src_data = '0;
      obs_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         src_data = src_data | src_terms[k];
         obs_data = obs_data | obs_terms[k];
      end
   end

   assign src_tag = |(src_sel & ent_tag);
   assign obs_tag = |(obs_sel & ent_tag);
   assign tgt_tag = |(tgt_sel & ent_tag);

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
   import fpstk_pkg::*;
#(
   parameter int DATA_W = 80,
   parameter int PTR_W  = 3,
   parameter logic [DATA_W-1:0] INDEF = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  src_form_e         form,
   input  logic [2:0]        idx,
   input  logic              inv_mask,
   input  logic [DATA_W-1:0] mem_value,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_tag,
   input  logic              tgt_tag,
   output logic [PTR_W-1:0]  top,
   output logic [PTR_W-1:0]  src_addr,
   output logic [PTR_W-1:0]  tgt_addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              done,
   output src_form_e         form_q,
   output logic              c1,
   output logic              fault
);

   logic ovf, unf, flt;

   assign tgt_addr = top - PTR_W'(1);
   assign src_addr = top + PTR_W'(idx);

   assign ovf   = tgt_tag;
   assign unf   = (form == SRC_STK) && !src_tag;
   assign flt   = ovf || unf;
   assign wr_en = accept && (!flt || inv_mask);

   always_comb begin
      if (flt)                  wr_data = INDEF;
      else if (form == SRC_STK) wr_data = src_data;
      else                      wr_data = mem_value;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top    <= '0;
         done   <= 1'b0;
         form_q <= SRC_M32;
         c1     <= 1'b0;
         fault  <= 1'b0;
      end else begin
         done  <= accept;
         fault <= accept && flt;
         if (accept) begin
            form_q <= form;
            c1     <= ovf;
         end
         if (wr_en) top <= tgt_addr;
      end
   end

endmodule

// File: rtl/fpstk_push_unit.sv
module fpstk_push_unit
   import fpstk_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int MAN_W  = 64,
   parameter int DEPTH  = 8,
   parameter int DATA_W = 1 + EXP_W + MAN_W,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        op_code,
   input  logic [7:0]        op_modrm,
   input  logic [DATA_W-1:0] mem_value,
   input  logic              inv_mask,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_value,
   output logic              rd_tag_valid,
   output logic [PTR_W-1:0]  top_ptr,
   output logic              done,
   output logic [1:0]        form_out,
   output logic              cond_c1,
   output logic              stack_fault
);

   localparam logic [DATA_W-1:0] INDEF =
      {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

   if (DATA_W != 1 + EXP_W + MAN_W) begin : g_bad_width
      $error("DATA_W must equal sign + exponent + mantissa");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("MAN_W must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (PTR_W != $clog2(DEPTH)) begin : g_bad_ptr
      $error("PTR_W must be clog2(DEPTH)");
   end

   logic              accept;
   src_form_e         form, form_q;
   logic [2:0]        idx;
   logic [PTR_W-1:0]  top, src_addr, tgt_addr;
   logic              wr_en, src_tag, tgt_tag;
   logic [DATA_W-1:0] wr_data, src_data;

   fpstk_decode u_dec (
      .op_valid (op_valid),
      .op_code  (op_code),
      .op_modrm (op_modrm),
      .accept   (accept),
      .form     (form),
      .idx      (idx)
   );

   fpstk_ctrl #(
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W),
      .INDEF  (INDEF)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .form      (form),
      .idx       (idx),
      .inv_mask  (inv_mask),
      .mem_value (mem_value),
      .src_data  (src_data),
      .src_tag   (src_tag),
      .tgt_tag   (tgt_tag),
      .top       (top),
      .src_addr  (src_addr),
      .tgt_addr  (tgt_addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .done      (done),
      .form_q    (form_q),
      .c1        (cond_c1),
      .fault     (stack_fault)
   );

   fpstk_regfile #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W)
   ) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (tgt_addr),
      .wr_data  (wr_data),
      .src_addr (src_addr),
      .src_data (src_data),
      .src_tag  (src_tag),
      .obs_addr (top + rd_idx),
      .obs_data (rd_value),
      .obs_tag  (rd_tag_valid),
      .tgt_tag  (tgt_tag)
   );

   assign top_ptr  = top;
   assign form_out = form_q;

endmodule

// File: rtl/fpstk_push_chk.sv
module fpstk_push_chk #(
   parameter int PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             inv_mask,
   input logic             done,
   input logic             stack_fault,
   input logic             cond_c1,
   input logic [PTR_W-1:0] top_ptr
);

   // R10
   done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(op_valid));

   // R10
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault |-> done);

   // R6
   c1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cond_c1) |-> stack_fault);

   // R4
   top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !stack_fault) |-> top_ptr == PTR_W'($past(top_ptr) - 1'b1));

   // R9
   unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stack_fault && !$past(inv_mask)) |-> top_ptr == $past(top_ptr));

   // R3
   idle_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(top_ptr));

   // R10
   c1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(cond_c1));

endmodule

bind fpstk_push_unit fpstk_push_chk #(.PTR_W(PTR_W)) u_push_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .inv_mask    (inv_mask),
   .done        (done),
   .stack_fault (stack_fault),
   .cond_c1     (cond_c1),
   .top_ptr     (top_ptr)
);

// File: tb/fpstk_push_unit_bench.sv
`timescale 1ns/1ps
module fpstk_push_unit_bench;

   localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = '0;
   logic [7:0]  op_modrm = '0;
   logic [79:0] mem_value = '0;
   logic        inv_mask = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [79:0] rd_value;
   logic        rd_tag_valid;
   logic [2:0]  top_ptr;
   logic        done;
   logic [1:0]  form_out;
   logic        cond_c1;
   logic        stack_fault;

   int n_chk = 0;
   int n_bad = 0;

   logic [79:0] mval [8];
   logic        mtag [8];
   logic [2:0]  mtop;
   logic        mc1;

   always #2 clk = ~clk;

   fpstk_push_unit u_fpstk_push_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .op_code      (op_code),
      .op_modrm     (op_modrm),
      .mem_value    (mem_value),
      .inv_mask     (inv_mask),
      .rd_idx       (rd_idx),
      .rd_value     (rd_value),
      .rd_tag_valid (rd_tag_valid),
      .top_ptr      (top_ptr),
      .done         (done),
      .form_out     (form_out),
      .cond_c1      (cond_c1),
      .stack_fault  (stack_fault)
   );

   task automatic check(input string req, input string what,
                        input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic exp_decode(input logic [7:0] opc, input logic [7:0] mrm,
                             output bit acc, output logic [1:0] frm);
      bit mem;
      mem = (mrm[7:6] != 2'b11);
      acc = 1'b1;
      if (opc == 8'hD9 && mem && mrm[5:3] == 3'd0)      frm = 2'd0;
      else if (opc == 8'hDD && mem && mrm[5:3] == 3'd0) frm = 2'd1;
      else if (opc == 8'hDB && mem && mrm[5:3] == 3'd5) frm = 2'd2;
      else if (opc == 8'hD9 && mrm[7:3] == 5'b11000)    frm = 2'd3;
      else begin
         acc = 1'b0;
         frm = 2'd0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      op_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         mtag[k] = 1'b0;
         mval[k] = '0;
      end
      mtop = 3'd0;
      mc1  = 1'b0;
      @(negedge clk);
   endtask

   // Drives one operation at a negedge; checks the results one negedge later.
   task automatic issue(input logic [7:0] opc, input logic [7:0] mrm,
                        input logic [79:0] data, input bit mask,
                        input string req, input bit last = 1'b1);
      bit          acc, ovf, unf, flt;
      logic [1:0]  frm;
      logic [2:0]  tgt, src;
      logic [79:0] v;
      op_code = opc; op_modrm = mrm; mem_value = data; inv_mask = mask;
      op_valid = 1'b1;
      exp_decode(opc, mrm, acc, frm);
      flt = 1'b0;
      if (acc) begin
         tgt = mtop - 3'd1;
         src = mtop + mrm[2:0];
         ovf = mtag[tgt];
         unf = (frm == 2'd3) && !mtag[src];
         flt = ovf || unf;
         v = flt ? INDEF : ((frm == 2'd3) ? mval[src] : data);
         mc1 = ovf;
         if (!flt || mask) begin
            mtop = tgt;
            mval[tgt] = v;
            mtag[tgt] = 1'b1;
         end
      end
      @(negedge clk);
      if (last) op_valid = 1'b0;
      check(acc ? req : "R3", "done", 80'(done), 80'(acc));
      if (acc) check("R2", "form_out", 80'(form_out), 80'(frm));
      check(acc ? "R6" : "R3", "cond_c1", 80'(cond_c1), 80'(mc1));
      check(acc ? req : "R3", "stack_fault", 80'(stack_fault), 80'(flt));
      check(acc ? "R4" : "R3", "top_ptr", 80'(top_ptr), 80'(mtop));
   endtask

   task automatic verify_stack(input string req);
      for (int k = 0; k < 8; k++) begin
         rd_idx = 3'(k);
         #1;
         check(req, $sformatf("tag ST(%0d)", k), 80'(rd_tag_valid),
               80'(mtag[3'(mtop + 3'(k))]));
         if (mtag[3'(mtop + 3'(k))])
            check(req, $sformatf("value ST(%0d)", k), rd_value,
                  mval[3'(mtop + 3'(k))]);
         if (k == 1) begin
            check("R10", "done pulse", 80'(done), 80'(0));
            check("R10", "fault pulse", 80'(stack_fault), 80'(0));
         end
         @(negedge clk);
      end
   endtask

   function automatic logic [79:0] pat(input int a, input int b);
      return {16'(16'h3FF0 + a), 32'(32'hC0DE_0000 + b), 32'(a * 977 + b * 31)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      check("R1", "top_ptr", 80'(top_ptr), 80'(0));
      check("R1", "done", 80'(done), 80'(0));
      check("R1", "cond_c1", 80'(cond_c1), 80'(0));
      check("R1", "stack_fault", 80'(stack_fault), 80'(0));
      for (int k = 0; k < 8; k++) begin
         rd_idx = 3'(k);
         #0.2;
         check("R1", "tag empty", 80'(rd_tag_valid), 80'(0));
      end

      // R4: fill with all three memory forms
      for (int n = 0; n < 8; n++) begin
         case (n % 3)
            0: issue(8'hD9, 8'h06, pat(n, 1), 1'b0, "R4");
            1: issue(8'hDD, 8'h45, pat(n, 2), 1'b0, "R4");
            default: issue(8'hDB, 8'h2E, pat(n, 3), 1'b0, "R4");
         endcase
         verify_stack("R4");
      end

      // R6, R8, R9: overflow on a full stack
      issue(8'hDD, 8'h00, pat(9, 9), 1'b0, "R9");
      verify_stack("R9");
      issue(8'hD9, 8'hC3, pat(9, 8), 1'b0, "R9");
      verify_stack("R9");
      issue(8'hD9, 8'h00, pat(9, 7), 1'b1, "R8");
      verify_stack("R8");
      issue(8'hD9, 8'hC0, pat(9, 6), 1'b1, "R8");
      verify_stack("R8");

      // R5, R7: register source at each depth and index, both masks
      for (int n = 1; n < 8; n++) begin
         for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 2; m++) begin
               do_reset();
               for (int j = 0; j < n; j++)
                  issue(8'hDB, 8'h28, pat(j + 20, n * 8 + i), 1'b0, "R4");
               issue(8'hD9, 8'(8'hC0 + i), pat(99, 0), m[0],
                     (i < n) ? "R5" : "R7");
               verify_stack((i < n) ? "R5" : (m != 0 ? "R8" : "R9"));
            end
         end
      end

      // R10: pushes on consecutive cycles
      do_reset();
      issue(8'hD9, 8'h00, pat(40, 1), 1'b0, "R10", 1'b0);
      issue(8'hD9, 8'hC0, pat(40, 2), 1'b0, "R10", 1'b0);
      issue(8'hDD, 8'h00, pat(40, 3), 1'b0, "R10");
      verify_stack("R10");

      // R2, R3: full decode sweep over the escape opcodes
      do_reset();
      for (int oc = 8'hD8; oc <= 8'hDF; oc++) begin
         for (int mr = 0; mr < 256; mr++) begin
            issue(8'(oc), 8'(mr), pat(oc, mr), mr[1], "R2");
            if ((mr % 16) == 0 || (mtop == 3'd0)) verify_stack("R2");
         end
      end
      verify_stack("R3");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule